// File: doc/BRIEF.md
# PCI Host Bridge Address Decoder

This unit sits on the CPU side of a host bridge. For each request it takes a 32-bit CPU address, a read/write flag, a byte count and a valid strobe, and decides which downstream target the request belongs to. The possible targets are a direct configuration window, the I/O space, a single interrupt-acknowledge location, and PCI memory. It forms the address that the target expects and registers the result one clock later. Requests that are malformed or unmapped come out flagged as errors with no target selected.

The I/O space can be mapped in two ways. A mode register holds the choice. In contiguous mode, the low 8 MiB of the I/O window passes address bits [15:0] straight through. In sparse mode, the page-number bits of the CPU address are folded down next to the low byte offset, so each small register group can live on its own CPU page. The block also merges the interrupt pins of a small set of PCI devices onto two interrupt lines. The merge swizzles the pins by device number.

Top module: `pci_host_addr_decode`

## Requirements
- R1: After reset, rsp_valid, rsp_error and irq_line are 0, and the I/O mode is contiguous.
- R2: An address in [0x8080_0000, 0x80C0_0000) selects target code 1 (configuration). rsp_addr[10:0] equals req_addr[10:0], rsp_addr[15:11] holds the device index, and rsp_addr[31:16] is 0.
- R3: The device index is the smallest k (0..10) for which req_addr[11+k] is 1. If none of req_addr[21:11] is set, the index is 11.
- R4: In contiguous mode, an address in [0x8000_0000, 0x8080_0000) selects target code 2 (I/O) with rsp_addr = req_addr[15:0].
- R5: In sparse mode, an address in the same window gives rsp_addr[4:0] = req_addr[4:0] and rsp_addr[15:5] = req_addr[22:12], with upper bits 0.
- R6: An address in [0x80C0_0000, 0xBF80_0000) selects target code 2 with rsp_addr = req_addr − 0x8000_0000, whatever the mode.
- R7: A one-byte read at 0xBFFF_FFF0 selects target code 3 (interrupt acknowledge). rsp_iack_data returns iack_vector as sampled with the request.
- R8: An address at or above 0xC000_0000 selects target code 4 (memory) with rsp_addr = req_addr − 0xC000_0000.
- R9: Any req_size other than 1, 2 or 4 (the size is a byte count) raises rsp_error with target code 0 and rsp_addr 0.
- R10: A write, or an access wider than one byte, to 0xBFFF_FFF0 raises rsp_error with target code 0.
- R11: An address below 0x8000_0000, or in [0xBF80_0000, 0xC000_0000) other than the acknowledge byte, raises rsp_error with target code 0.
- R12: A mode_set pulse loads mode_level into the mode register (0 = contiguous, 1 = sparse). A request in the same cycle is decoded with the previous mode.
- R13: dev_irq bit d*4+n is pin n of device d. irq_line[L], registered one cycle, is the OR of every pin with (n+d) mod 2 = L.
- R14: rsp_valid follows req_valid by exactly one cycle, and it echoes req_write and req_size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | CPU address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes |
| mode_set | input | 1 | Load pulse for the I/O mode register |
| mode_level | input | 1 | New mode value (1 = sparse) |
| iack_vector | input | 8 | Vector from the interrupt controller |
| dev_irq | input | NUM_DEV*4 | Device interrupt pin levels |
| rsp_valid | output | 1 | Decoded result valid |
| rsp_target | output | 3 | 0 none, 1 config, 2 I/O, 3 int-ack, 4 memory |
| rsp_addr | output | 32 | Translated downstream address |
| rsp_write | output | 1 | Echoed direction |
| rsp_size | output | 3 | Echoed size |
| rsp_error | output | 1 | Request rejected |
| rsp_iack_data | output | 8 | Acknowledge vector |
| irq_line | output | 2 | Merged interrupt lines |

## Verification
The collision of interest is a mode change and an I/O request in the same cycle. The mode write must not affect that request. The bench provokes it by pulsing mode_set with a sparse-window request in the same cycle. That request must show the old contiguous translation, and the request right after it must show the sparse one. A second overlap is an interrupt-pin sweep running alongside requests. Each is judged against values that the bench computes arithmetically.

// File: rtl/pcihd_pkg.sv
package pcihd_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_CFG  = 3'd1,
    TGT_IO   = 3'd2,
    TGT_IACK = 3'd3,
    TGT_MEM  = 3'd4
  } target_e;
endpackage

// File: rtl/pcihd_cfg_xlate.sv
module pcihd_cfg_xlate #(
  parameter int ADDR_W = 32,
  parameter int SEL_LSB = 11,
  parameter int SEL_N = 11,
  parameter int OUT_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  cfg_addr
);
  localparam int IDX_W = OUT_W - SEL_LSB;

  logic [IDX_W-1:0] idx;

  // lowest set select bit wins; no bit set gives SEL_N
  always_comb begin
    idx = IDX_W'(SEL_N);
    for (int k = SEL_N - 1; k >= 0; k--) begin
      if (addr[SEL_LSB + k]) idx = IDX_W'(k);
    end
  end

  assign cfg_addr = {idx, addr[SEL_LSB-1:0]};
endmodule

// File: rtl/pcihd_io_xlate.sv
module pcihd_io_xlate #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int LOW_KEEP = 5,
  parameter int PAGE_LSB = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sparse_mode,
  output logic [PORT_W-1:0] port_addr
);
  localparam int HI_W = PORT_W - LOW_KEEP;

  logic [PORT_W-1:0] flat_addr;
  logic [PORT_W-1:0] packed_addr;

  assign flat_addr   = addr[PORT_W-1:0];
  assign packed_addr = {addr[PAGE_LSB+HI_W-1:PAGE_LSB], addr[LOW_KEEP-1:0]};
  assign port_addr   = sparse_mode ? packed_addr : flat_addr;
endmodule

// File: rtl/pcihd_region_decode.sv
module pcihd_region_decode
  import pcihd_pkg::*;
#(
  parameter logic [31:0] IO_BASE     = 32'h8000_0000,
  parameter logic [31:0] SPARSE_SIZE = 32'h0080_0000,
  parameter logic [31:0] IO_SIZE     = 32'h3F80_0000,
  parameter logic [31:0] CFG_BASE    = 32'h8080_0000,
  parameter logic [31:0] CFG_SIZE    = 32'h0040_0000,
  parameter logic [31:0] IACK_ADDR   = 32'hBFFF_FFF0,
  parameter logic [31:0] MEM_BASE    = 32'hC000_0000
) (
  input  logic [31:0] addr,
  input  logic        write,
  input  logic [2:0]  size,
  output target_e     target,
  output logic        sparse_hit,
  output logic        err
);
  localparam logic [31:0] SPARSE_END = IO_BASE + SPARSE_SIZE;
  localparam logic [31:0] IO_END     = IO_BASE + IO_SIZE;
  localparam logic [31:0] CFG_END    = CFG_BASE + CFG_SIZE;

  logic size_ok;
  assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);

  always_comb begin
    target     = TGT_NONE;
    sparse_hit = 1'b0;
    err        = 1'b0;
    if (!size_ok) begin
      err = 1'b1;
    end else if (addr == IACK_ADDR) begin
      if (!write && size == 3'd1) target = TGT_IACK;
      else err = 1'b1;
    end else if (addr >= MEM_BASE) begin
      target = TGT_MEM;
    end else if (addr >= CFG_BASE && addr < CFG_END) begin
      target = TGT_CFG;
    end else if (addr >= IO_BASE && addr < SPARSE_END) begin
      target     = TGT_IO;
      sparse_hit = 1'b1;
    end else if (addr >= IO_BASE && addr < IO_END) begin
      target = TGT_IO;
    end else begin
      err = 1'b1;
    end
  end
endmodule

// File: rtl/pcihd_irq_router.sv
module pcihd_irq_router #(
  parameter int NUM_DEV = 4,
  parameter int PINS = 4,
  parameter int LINES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_DEV*PINS-1:0] pin_level,
  output logic [LINES-1:0]        line_out
);
  logic [LINES-1:0] line_c;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_comb begin
      line_c[l] = 1'b0;
      for (int d = 0; d < NUM_DEV; d++) begin
        for (int n = 0; n < PINS; n++) begin
          if (((n + d) % LINES) == l) line_c[l] = line_c[l] | pin_level[d*PINS+n];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line_out <= '0;
    else     line_out <= line_c;
  end
endmodule

// File: rtl/pci_host_addr_decode.sv
module pci_host_addr_decode
  import pcihd_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  input  logic                 req_write,
  input  logic [2:0]           req_size,
  input  logic                 mode_set,
  input  logic                 mode_level,
  input  logic [VEC_W-1:0]     iack_vector,
  input  logic [NUM_DEV*4-1:0] dev_irq,
  output logic                 rsp_valid,
  output logic [2:0]           rsp_target,
  output logic [31:0]          rsp_addr,
  output logic                 rsp_write,
  output logic [2:0]           rsp_size,
  output logic                 rsp_error,
  output logic [VEC_W-1:0]     rsp_iack_data,
  output logic [1:0]           irq_line
);
  localparam logic [31:0] IO_BASE  = 32'h8000_0000;
  localparam logic [31:0] MEM_BASE = 32'hC000_0000;
  localparam int PORT_W = 16;

  logic        mode_q;
  target_e     hit;
  logic        sparse_hit;
  logic        dec_err;
  logic [PORT_W-1:0] cfg_addr;
  logic [PORT_W-1:0] io_addr;
  logic [31:0] next_addr;

  pcihd_region_decode i_region (
    .addr(req_addr), .write(req_write), .size(req_size),
    .target(hit), .sparse_hit(sparse_hit), .err(dec_err)
  );

  pcihd_cfg_xlate #(.OUT_W(PORT_W)) i_cfg (
    .addr(req_addr), .cfg_addr(cfg_addr)
  );

  pcihd_io_xlate #(.PORT_W(PORT_W)) i_io (
    .addr(req_addr), .sparse_mode(mode_q), .port_addr(io_addr)
  );

  pcihd_irq_router #(.NUM_DEV(NUM_DEV), .PINS(4), .LINES(2)) i_irq (
    .clk(clk), .rst(rst), .pin_level(dev_irq), .line_out(irq_line)
  );

  always_comb begin
    unique case (hit)
      TGT_CFG: next_addr = 32'(cfg_addr);
      TGT_IO:  next_addr = sparse_hit ? 32'(io_addr) : (req_addr - IO_BASE);
      TGT_MEM: next_addr = req_addr - MEM_BASE;
      default: next_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (mode_set) mode_q <= mode_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_target    <= 3'd0;
      rsp_addr      <= '0;
      rsp_write     <= 1'b0;
      rsp_size      <= '0;
      rsp_error     <= 1'b0;
      rsp_iack_data <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_target    <= req_valid ? hit : TGT_NONE;
      rsp_addr      <= req_valid ? next_addr : '0;
      rsp_write     <= req_write;
      rsp_size      <= req_size;
      rsp_error     <= req_valid & dec_err;
      rsp_iack_data <= (req_valid && hit == TGT_IACK) ? iack_vector : '0;
    end
  end
endmodule

// File: rtl/pcihd_checker.sv
module pcihd_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [2:0]  req_size,
  input logic        mode_set,
  input logic        mode_level,
  input logic        mode_q,
  input logic        rsp_valid,
  input logic [2:0]  rsp_target,
  input logic [31:0] rsp_addr,
  input logic        rsp_write,
  input logic [2:0]  rsp_size,
  input logic        rsp_error
);
  assert_rsp_follows_R14: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R14: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_rsp_echo_R14: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_size == $past(req_size)) && (rsp_write == $past(req_write)));
  assert_err_no_target_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_error) |-> (rsp_target == 3'd0));
  assert_iack_byte_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_target == 3'd3) |-> (rsp_size == 3'd1 && !rsp_write));
  assert_mode_load_R12: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> (mode_q == $past(mode_level)));
  assert_mode_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !mode_set |=> $stable(mode_q));
  assert_cfg_index_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_target == 3'd1) |-> (rsp_addr[31:16] == 16'd0 && rsp_addr[15:11] <= 5'd11));
  assert_mem_offset_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_target == 3'd4) |-> (rsp_addr < 32'h4000_0000));
endmodule

bind pci_host_addr_decode pcihd_checker i_pcihd_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .mode_set(mode_set), .mode_level(mode_level),
  .mode_q(mode_q), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
  .rsp_addr(rsp_addr), .rsp_write(rsp_write), .rsp_size(rsp_size),
  .rsp_error(rsp_error)
);

// File: tb/test_pci_host_addr_decode.sv
`timescale 1ns/1ps
module test_pci_host_addr_decode;
  localparam int NUM_DEV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [2:0] req_size = 3'd1;
  logic mode_set = 1'b0;
  logic mode_level = 1'b0;
  logic [7:0] iack_vector = 8'h00;
  logic [NUM_DEV*4-1:0] dev_irq = '0;
  logic rsp_valid;
  logic [2:0] rsp_target;
  logic [31:0] rsp_addr;
  logic rsp_write;
  logic [2:0] rsp_size;
  logic rsp_error;
  logic [7:0] rsp_iack_data;
  logic [1:0] irq_line;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pci_host_addr_decode #(.NUM_DEV(NUM_DEV)) i_pci_host_addr_decode (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .mode_set(mode_set),
    .mode_level(mode_level), .iack_vector(iack_vector), .dev_irq(dev_irq),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_addr(rsp_addr),
    .rsp_write(rsp_write), .rsp_size(rsp_size), .rsp_error(rsp_error),
    .rsp_iack_data(rsp_iack_data), .irq_line(irq_line)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result is registered on the next rising edge
  task automatic access(input string req, input logic [31:0] a, input logic w,
                        input logic [2:0] s, input logic [2:0] et,
                        input logic [31:0] ea, input logic eerr);
    req_valid = 1'b1; req_addr = a; req_write = w; req_size = s;
    @(negedge clk);
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " target"}, 64'(rsp_target), 64'(et));
    check({req, " addr"}, 64'(rsp_addr), 64'(ea));
    check({req, " error"}, 64'(rsp_error), 64'(eerr));
    check({req, " echo"}, 64'({rsp_write, rsp_size}), 64'({w, s}));
    req_valid = 1'b0;
  endtask

  task automatic set_mode(input logic lvl);
    mode_set = 1'b1; mode_level = lvl;
    @(negedge clk);
    mode_set = 1'b0;
  endtask

  function automatic logic [31:0] sparse_of(input logic [31:0] a);
    return ((a / 32'd4096) % 32'd2048) * 32'd32 + (a % 32'd32);
  endfunction

  function automatic logic [1:0] lines_of(input logic [NUM_DEV*4-1:0] p);
    logic [1:0] r = 2'b00;
    for (int d = 0; d < NUM_DEV; d++)
      for (int n = 0; n < 4; n++)
        if (p[d*4+n]) r[(n + d) % 2] = 1'b1;
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 rsp_error", 64'(rsp_error), 64'd0);
    check("R1 irq_line", 64'(irq_line), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // R1: mode is contiguous after reset
    access("R1 contiguous after reset", 32'h8012_3456, 1'b0, 3'd2, 3'd2, 32'h0000_3456, 1'b0);
    // R14: idle cycle gives no response
    @(negedge clk);
    check("R14 idle", 64'(rsp_valid), 64'd0);

    // R2 R3: configuration index sweep, higher bits set as noise
    for (int k = 0; k <= 11; k++) begin
      a = 32'h8080_0000 | 32'h5A5 | ((k < 11) ? (32'h1 << (11 + k)) : 32'h0);
      if (k < 10) a = a | 32'h0020_0000;
      access("R2 R3 cfg index", a, k[0], 3'd4, 3'd1, (32'(k) << 11) | 32'h5A5, 1'b0);
    end
    access("R2 cfg last byte", 32'h80BF_FFFF, 1'b0, 3'd1, 3'd1, 32'h0000_07FF, 1'b0);

    // R4: contiguous window
    for (int i = 0; i < 16; i++) begin
      a = 32'h8000_0000 + 32'(i) * 32'h0008_1357;
      access("R4 contiguous io", a, i[0], 3'd1, 3'd2, a % 32'h1_0000, 1'b0);
    end

    // R12: mode change collides with a request
    mode_set = 1'b1; mode_level = 1'b1;
    access("R12 same-cycle uses old mode", 32'h807F_F01F, 1'b0, 3'd4, 3'd2, 32'h0000_F01F, 1'b0);
    mode_set = 1'b0;
    access("R12 next uses new mode", 32'h807F_F01F, 1'b0, 3'd4, 3'd2, sparse_of(32'h807F_F01F), 1'b0);

    // R5: sparse window sweep
    for (int i = 0; i < 24; i++) begin
      a = 32'h8000_0000 + 32'(i) * 32'h0005_5AB3;
      access("R5 sparse io", a, 1'b1, 3'd2, 3'd2, sparse_of(a), 1'b0);
    end

    // R6: plain I/O region, both modes
    access("R6 plain io low", 32'h80C0_0000, 1'b0, 3'd1, 3'd2, 32'h00C0_0000, 1'b0);
    access("R6 plain io high", 32'hBF7F_FFFF, 1'b1, 3'd1, 3'd2, 32'h3F7F_FFFF, 1'b0);
    set_mode(1'b0);
    access("R6 plain io contiguous", 32'h9234_5678, 1'b0, 3'd4, 3'd2, 32'h1234_5678, 1'b0);

    // R7: interrupt acknowledge
    iack_vector = 8'hA7;
    access("R7 iack", 32'hBFFF_FFF0, 1'b0, 3'd1, 3'd3, 32'h0, 1'b0);
    check("R7 iack data", 64'(rsp_iack_data), 64'hA7);
    // R10: bad acknowledge accesses
    access("R10 iack write", 32'hBFFF_FFF0, 1'b1, 3'd1, 3'd0, 32'h0, 1'b1);
    access("R10 iack wide", 32'hBFFF_FFF0, 1'b0, 3'd2, 3'd0, 32'h0, 1'b1);
    access("R10 iack word", 32'hBFFF_FFF0, 1'b0, 3'd4, 3'd0, 32'h0, 1'b1);

    // R8: memory
    access("R8 mem base", 32'hC000_0000, 1'b0, 3'd4, 3'd4, 32'h0, 1'b0);
    access("R8 mem top", 32'hFFFF_FFFF, 1'b1, 3'd1, 3'd4, 32'h3FFF_FFFF, 1'b0);
    access("R8 mem mid", 32'hDEAD_BEEC, 1'b0, 3'd2, 3'd4, 32'h1EAD_BEEC, 1'b0);

    // R9: size sweep
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2 || s == 4)
        access("R9 good size", 32'hC000_1000, 1'b0, 3'(s), 3'd4, 32'h1000, 1'b0);
      else
        access("R9 bad size", 32'hC000_1000, 1'b0, 3'(s), 3'd0, 32'h0, 1'b1);
    end

    // R11: unmapped
    access("R11 below io", 32'h7FFF_FFFF, 1'b0, 3'd1, 3'd0, 32'h0, 1'b1);
    access("R11 zero", 32'h0000_0000, 1'b1, 3'd4, 3'd0, 32'h0, 1'b1);
    access("R11 gap", 32'hBF80_0000, 1'b0, 3'd1, 3'd0, 32'h0, 1'b1);
    access("R11 near iack", 32'hBFFF_FFF1, 1'b0, 3'd1, 3'd0, 32'h0, 1'b1);

    // R13: interrupt merge, walking ones then pseudo-random patterns
    for (int b = 0; b < NUM_DEV*4; b++) begin
      dev_irq = '0;
      dev_irq[b] = 1'b1;
      @(negedge clk);
      check("R13 walking pin", 64'(irq_line), 64'(lines_of(dev_irq)));
    end
    lfsr = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dev_irq = lfsr & ((i % 3 == 0) ? 16'h1111 : 16'hFFFF);
      @(negedge clk);
      check("R13 pattern", 64'(irq_line), 64'(lines_of(dev_irq)));
    end
    dev_irq = '0;
    @(negedge clk);
    check("R13 all low", 64'(irq_line), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule